// File: doc/BRIEF.md
# Three-Source Maskable Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core from three sources: a rising edge on an asynchronous external pin, a single-cycle overflow pulse from an 8-bit timer, and any change on the upper nibble of an input port. Each request sets a sticky flag bit in one CPU-visible control register. That register also holds a per-source enable bit and a global enable bit. Flags latch whatever the enables are set to. Only software clears a flag, by writing it to zero.

When the global enable is set and any flag is set together with its enable, the block raises an acceptance strobe for one cycle. On that strobe the core pushes its return address and loads the program counter from the fixed vector output. In the same edge the block clears the global enable. A return-from-interrupt pulse from the core sets the global enable again. A separate wake output follows any enabled pending request, whatever the global enable, so the core can leave sleep. The program counter, the stack and the instruction decode live in the core, and this block only exchanges strobes with them.

Top module: `irq_ctrl`

## Requirements
- R1: The control register reads as {bit7 global enable, bit6 constant 0, bit5 timer enable, bit4 external enable, bit3 port-change enable, bit2 timer flag, bit1 external flag, bit0 port-change flag}. Its reset value is 0x00. A write loads every bit except bit6 at the next clock edge.
- R2: A high `tmr_ovf_i` sets bit2 at the next edge, whatever the enables. A hardware event in the same cycle as a software write of 0 to a flag leaves that flag set.
- R3: `irq_take_o` is high exactly when the global enable is 1 and at least one flag is 1 together with its enable bit.
- R4: The edge at which `irq_take_o` is high clears the global enable. This takes priority over a return pulse and over a register write in the same cycle.
- R5: `vec_o` presents the jump target 0x0004.
- R6: Acceptance never clears a flag. A flag left set is taken again as soon as the global enable is restored.
- R7: `ext_pin_i` passes through two synchronizer flops. A 0-to-1 transition sets bit1 at the third rising clock edge after the pin changes. A pin held high or a falling edge sets nothing.
- R8: A `retfie_i` pulse sets the global enable at the next edge, unless an acceptance occurs in that same cycle.
- R9: Bit0 is set at every edge where `port_hi_i` differs from a snapshot. The snapshot is loaded from `port_hi_i` at each edge with `port_rd_i` high, and reset loads it with 0.
- R10: `wake_o` is high exactly when some flag is set together with its enable, whatever the global enable.
- R11: A request that becomes pending while the global enable is 0 stays in its flag. It is accepted in the first cycle after the global enable becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Write strobe for the control register |
| reg_wdata_i | input | 8 | Write data for the control register |
| reg_rdata_o | output | 8 | Current control register value |
| ext_pin_i | input | 1 | Asynchronous external interrupt pin |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| port_hi_i | input | 4 | Upper nibble of the input port pins |
| port_rd_i | input | 1 | Core reads the port, which reloads the change snapshot |
| retfie_i | input | 1 | Return-from-interrupt pulse, issued with the stack pop |
| irq_take_o | output | 1 | Acceptance: push the return address and jump to vec_o |
| vec_o | output | 13 | Interrupt vector address |
| wake_o | output | 1 | Enabled request pending, used to leave sleep |

## Verification
A vector table drives writes, timer pulses and return pulses in orders that separate the cases that matter. One order has a request arriving while the global enable is off and taken later. Another has a return with the flag still set, so the request is taken again. Others have acceptance and a write in the same cycle, and an event against a write of zero. Directed runs on the external pin sample one cycle before and at the expected latency, then hold the pin high and lower it. These runs tell a true rising-edge detector from a level detector or a detector with wrong timing. Port-change runs alter the nibble before and after a port read, which shows whether the snapshot is taken at the read.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DATA_W   = 8;
  localparam int NSRC     = 3;
  localparam int SRC_CHG  = 0;
  localparam int SRC_EXT  = 1;
  localparam int SRC_TMR  = 2;
  localparam int FLAG_LSB = 0;
  localparam int EN_LSB   = FLAG_LSB + NSRC;
  localparam int GIE_BIT  = DATA_W - 1;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= pin_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[i] <= 1'b0;
      else         sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/irq_port_chg.sv
module irq_port_chg #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pins_i,
  input  logic         rd_i,
  output logic         chg_o
);
  logic [W-1:0] snap_q;

  // snapshot follows the pins on every port read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   snap_q <= '0;
    else if (rd_i) snap_q <= pins_i;
  end

  assign chg_o = |(pins_i ^ snap_q);
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NSRC-1:0]   evt_i,
  input  logic              take_i,
  input  logic              ret_i,
  output logic              gie_o,
  output logic [NSRC-1:0]   en_o,
  output logic [NSRC-1:0]   flag_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    // hardware event wins over a software write of zero
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_o[i] <= 1'b0;
      else         flag_o[i] <= (wr_i ? wdata_i[FLAG_LSB+i] : flag_o[i]) | evt_i[i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   en_o[i] <= 1'b0;
      else if (wr_i) en_o[i] <= wdata_i[EN_LSB+i];
    end
  end

  // acceptance > return > write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gie_o <= 1'b0;
    else if (take_i) gie_o <= 1'b0;
    else if (ret_i)  gie_o <= 1'b1;
    else if (wr_i)   gie_o <= wdata_i[GIE_BIT];
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int          PC_W      = 13,
  parameter int          PORT_W    = 4,
  parameter int          SYNC_STG  = 2,
  parameter logic [12:0] IRQ_VEC   = 13'h0004
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              ext_pin_i,
  input  logic              tmr_ovf_i,
  input  logic [PORT_W-1:0] port_hi_i,
  input  logic              port_rd_i,
  input  logic              retfie_i,
  output logic              irq_take_o,
  output logic [PC_W-1:0]   vec_o,
  output logic              wake_o
);
  logic            ext_rise;
  logic            port_chg;
  logic [NSRC-1:0] evt;
  logic            gie;
  logic [NSRC-1:0] en;
  logic [NSRC-1:0] flag;
  logic            pending;

  irq_edge_sync #(.STAGES(SYNC_STG)) u_ext_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_pin_i),
    .rise_o (ext_rise)
  );

  irq_port_chg #(.W(PORT_W)) u_port_chg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pins_i (port_hi_i),
    .rd_i   (port_rd_i),
    .chg_o  (port_chg)
  );

  always_comb begin
    evt          = '0;
    evt[SRC_CHG] = port_chg;
    evt[SRC_EXT] = ext_rise;
    evt[SRC_TMR] = tmr_ovf_i;
  end

  irq_ctrl_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i),
    .evt_i   (evt),
    .take_i  (irq_take_o),
    .ret_i   (retfie_i),
    .gie_o   (gie),
    .en_o    (en),
    .flag_o  (flag)
  );

  assign pending    = |(flag & en);
  assign irq_take_o = gie & pending;
  assign wake_o     = pending;
  assign vec_o      = IRQ_VEC[PC_W-1:0];

  always_comb begin
    reg_rdata_o                    = '0;
    reg_rdata_o[GIE_BIT]           = gie;
    reg_rdata_o[EN_LSB +: NSRC]    = en;
    reg_rdata_o[FLAG_LSB +: NSRC]  = flag;
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_wr_i,
  input logic       tmr_ovf_i,
  input logic       retfie_i,
  input logic [7:0] reg_rdata_o,
  input logic       irq_take_o,
  input logic       wake_o
);
  AST_TAKE_NEEDS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |-> reg_rdata_o[7]); // R3
  AST_GIE_DROP_ON_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |=> !reg_rdata_o[7]); // R4
  AST_FLAGS_KEPT_ON_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_take_o && !reg_wr_i) |=> (($past(reg_rdata_o[2:0]) & ~reg_rdata_o[2:0]) == 3'b000)); // R6
  AST_RET_SETS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retfie_i && !irq_take_o) |=> reg_rdata_o[7]); // R8
  AST_TMR_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_ovf_i |=> reg_rdata_o[2]); // R2
  AST_TAKE_IMPLIES_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |-> wake_o); // R10
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .tmr_ovf_i   (tmr_ovf_i),
  .retfie_i    (retfie_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_take_o  (irq_take_o),
  .wake_o      (wake_o)
);

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        ext_pin_i = 1'b0;
  logic        tmr_ovf_i = 1'b0;
  logic [3:0]  port_hi_i = '0;
  logic        port_rd_i = 1'b0;
  logic        retfie_i = 1'b0;
  logic        irq_take_o;
  logic [12:0] vec_o;
  logic        wake_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_ctrl u_irq_ctrl (
    .clk_i, .rst_ni, .reg_wr_i, .reg_wdata_i, .reg_rdata_o, .ext_pin_i,
    .tmr_ovf_i, .port_hi_i, .port_rd_i, .retfie_i, .irq_take_o, .vec_o, .wake_o
  );

  // {wr, wdata[7:0], tmr, ret, exp_rd[7:0], exp_take, exp_wake}
  localparam int NROW = 15;
  localparam logic [20:0] TBL [NROW] = '{
    {1'b1, 8'h20, 1'b0, 1'b0, 8'h20, 1'b0, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b0, 8'h24, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h24, 1'b0, 1'b1},
    {1'b1, 8'hA4, 1'b0, 1'b0, 8'hA4, 1'b1, 1'b1},
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h24, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b0, 1'b1, 8'hA4, 1'b1, 1'b1},
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h24, 1'b0, 1'b1},
    {1'b1, 8'h20, 1'b0, 1'b0, 8'h20, 1'b0, 1'b0},
    {1'b1, 8'hA0, 1'b0, 1'b0, 8'hA0, 1'b0, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b0, 8'hA4, 1'b1, 1'b1},
    {1'b1, 8'hA0, 1'b0, 1'b0, 8'h20, 1'b0, 1'b0},
    {1'b1, 8'h40, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
    {1'b1, 8'h1F, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b1},
    {1'b1, 8'h00, 1'b1, 1'b0, 8'h04, 1'b0, 1'b0},
    {1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}
  };

  function automatic string row_req(int i);
    case (i)
      0, 7, 8, 14: return "R1";
      1, 2:        return "R2 R10";
      3:           return "R11 R3";
      4:           return "R4";
      5, 6:        return "R6 R8";
      9:           return "R3 R2";
      10:          return "R4";
      11:          return "R1";
      12:          return "R10";
      default:     return "R2";
    endcase
  endfunction

  task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr_i = 1'b1; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset", {5'd0, reg_rdata_o}, 13'h00);
    chk("R3 reset take", {12'd0, irq_take_o}, 13'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after reset", {5'd0, reg_rdata_o}, 13'h00);

    for (int i = 0; i < NROW; i++) begin
      reg_wr_i    = TBL[i][20];
      reg_wdata_i = TBL[i][19:12];
      tmr_ovf_i   = TBL[i][11];
      retfie_i    = TBL[i][10];
      @(negedge clk_i);
      reg_wr_i = 1'b0; reg_wdata_i = '0; tmr_ovf_i = 1'b0; retfie_i = 1'b0;
      chk(row_req(i), {5'd0, reg_rdata_o}, {5'd0, TBL[i][9:2]});
      chk(row_req(i), {12'd0, irq_take_o}, {12'd0, TBL[i][1]});
      chk(row_req(i), {12'd0, wake_o}, {12'd0, TBL[i][0]});
    end

    // R7 external pin: latency, level, falling edge
    wr(8'h90);
    ext_pin_i = 1'b1;
    @(posedge clk_i); @(posedge clk_i); @(negedge clk_i);
    chk("R7 not before third edge", {5'd0, reg_rdata_o}, 13'h90);
    @(negedge clk_i);
    chk("R7 flag at third edge", {5'd0, reg_rdata_o}, 13'h92);
    chk("R3 take on ext", {12'd0, irq_take_o}, 13'h1);
    chk("R5 vector", vec_o, 13'h0004);
    @(negedge clk_i);
    chk("R4 gie cleared", {5'd0, reg_rdata_o}, 13'h12);
    wr(8'h90);
    chk("R7 level held, cleared", {5'd0, reg_rdata_o}, 13'h90);
    repeat (3) @(negedge clk_i);
    chk("R7 high level no retrigger", {5'd0, reg_rdata_o}, 13'h90);
    ext_pin_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk("R7 falling edge ignored", {5'd0, reg_rdata_o}, 13'h90);
    wr(8'h00);

    // R9 port change
    wr(8'h08);
    port_hi_i = 4'b0100;
    @(negedge clk_i);
    chk("R9 mismatch sets flag", {5'd0, reg_rdata_o}, 13'h09);
    chk("R10 wake with gie clear", {12'd0, wake_o}, 13'h1);
    chk("R3 no take with gie clear", {12'd0, irq_take_o}, 13'h0);
    port_rd_i = 1'b1;
    @(negedge clk_i);
    port_rd_i = 1'b0;
    wr(8'h08);
    chk("R9 cleared after read", {5'd0, reg_rdata_o}, 13'h08);
    repeat (2) @(negedge clk_i);
    chk("R9 snapshot matches", {5'd0, reg_rdata_o}, 13'h08);
    port_hi_i = 4'b0110;
    @(negedge clk_i);
    chk("R9 new change sets flag", {5'd0, reg_rdata_o}, 13'h09);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule